// File: doc/BRIEF.md
# Power-Fail Sleep and Wake Sequencer

This block is the digital control of a power manager for a processor that runs on harvested energy with no battery. Two comparator inputs describe the supply: a good-voltage level and a fail warning. When the fail warning appears while the processor is running, the sequencer raises a sleep request. It keeps the storage-capacitor supply switched on until the processor reports that its state has been copied into nonvolatile cells, and only then releases the supply. A timeout stops the hold from lasting forever, and a sticky error flag records when the timeout was used.

When the supply comes back, the sequencer switches the processor supply on first. It then waits for the good-voltage comparator to stay high for a set number of consecutive cycles. Only after that wait does it issue a one-cycle wake pulse, which tells the processor to restore its state. The sequencer is meant to keep working under fast, repeated interruptions, such as a supply that is switched on and off as a square wave.

Top module: `pwr_seq`

## Requirements
- R1: After reset, supply_en_o, sleep_o, wake_o and err_o are all 0.
- R2: The supply is off. The cycle after the sequencer samples v_ok_i=1 with v_fail_i=0, supply_en_o is 1. wake_o is not yet asserted.
- R3: wake_o rises STABLE_CYCLES+2 cycles after v_ok_i is first sampled high from the off state. This counts one power-on cycle and the cycle that enters the wait. wake_o lasts exactly one cycle.
- R4: A low v_ok_i during the stability wait restarts the consecutive-cycle count from zero, which delays wake accordingly.
- R5: v_fail_i=1 during power-up or the stability wait turns supply_en_o off on the next cycle, and no wake pulse is issued.
- R6: v_fail_i=1 while running sets sleep_o on the next cycle. supply_en_o stays 1 while sleep_o is 1.
- R7: backup_done_i is sampled from the second sleep cycle onward. When it is seen, supply_en_o and sleep_o both fall on the next cycle, and err_o is cleared.
- R8: Suppose backup_done_i never arrives. Then sleep_o stays high for BACKUP_TIMEOUT+1 cycles, after which the supply is released and err_o becomes 1. err_o stays 1 through later power-ups until a backup finishes with backup_done_i.
- R9: Repeated cycles of power-up, run, failure and backup each complete correctly, back to back.
- R10: wake_o and sleep_o are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| v_ok_i | input | 1 | Good-voltage comparator (1 = supply above the restart level) |
| v_fail_i | input | 1 | Fail-warning comparator (1 = supply collapsing) |
| backup_done_i | input | 1 | Processor reports its state is saved |
| supply_en_o | output | 1 | Processor supply switch enable |
| sleep_o | output | 1 | Sleep request to the processor |
| wake_o | output | 1 | One-cycle restore pulse |
| err_o | output | 1 | Sticky flag: the last backup ended by timeout |

## Verification
The bench measures the exact latency from comparator rise to wake pulse. A design that skipped the supply-first cycle, or miscounted the wait, would wake one cycle early or late. It drops the good comparator partway through the wait, so a design that paused the count instead of restarting it would wake too soon. It asserts a failure during the wait, which catches a design that still lets a wake pulse escape. It also withholds the backup acknowledge, to catch a design that releases the supply early or forgets the error flag. A square-wave loop of back-to-back interruptions exposes any counter or flag state that leaks from one episode into the next.

// File: rtl/pwr_seq.sv
module pwr_seq #(
  parameter int STABLE_CYCLES  = 8,
  parameter int BACKUP_TIMEOUT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic v_ok_i,
  input  logic v_fail_i,
  input  logic backup_done_i,
  output logic supply_en_o,
  output logic sleep_o,
  output logic wake_o,
  output logic err_o
);
  localparam int SW = $clog2(STABLE_CYCLES + 1);
  localparam int TW = $clog2(BACKUP_TIMEOUT + 1);
  localparam logic [SW-1:0] STAB_LAST = SW'(STABLE_CYCLES - 1);
  localparam logic [TW-1:0] TMO_LAST  = TW'(BACKUP_TIMEOUT - 1);

  typedef enum logic [2:0] {
    S_OFF, S_PWRON, S_SETTLE, S_RUN, S_SLPREQ, S_HOLD
  } st_t;

  st_t           st, nxt;
  logic [SW-1:0] stab_cnt;
  logic [TW-1:0] tmo_cnt;
  logic          wake_q, err_q;

  always_comb begin
    nxt = st;
    case (st)
      S_OFF:    if (v_ok_i && !v_fail_i) nxt = S_PWRON;
      S_PWRON:  nxt = v_fail_i ? S_OFF : S_SETTLE;
      S_SETTLE: if (v_fail_i) nxt = S_OFF;
                else if (v_ok_i && stab_cnt == STAB_LAST) nxt = S_RUN;
      S_RUN:    if (v_fail_i) nxt = S_SLPREQ;
      S_SLPREQ: nxt = S_HOLD;
      S_HOLD:   if (backup_done_i || tmo_cnt == TMO_LAST) nxt = S_OFF;
      default:  nxt = S_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_OFF;
      stab_cnt <= '0;
      tmo_cnt  <= '0;
      wake_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      st     <= nxt;
      wake_q <= (st == S_SETTLE) && (nxt == S_RUN);
      if (st == S_SETTLE && v_ok_i && stab_cnt != STAB_LAST)
        stab_cnt <= stab_cnt + 1'b1;
      else
        stab_cnt <= '0;
      if (st == S_HOLD)
        tmo_cnt <= tmo_cnt + 1'b1;
      else
        tmo_cnt <= '0;
      if (st == S_HOLD && backup_done_i)
        err_q <= 1'b0;
      else if (st == S_HOLD && tmo_cnt == TMO_LAST)
        err_q <= 1'b1;
    end
  end

  assign supply_en_o = (st != S_OFF);
  assign sleep_o     = (st == S_SLPREQ) || (st == S_HOLD);
  assign wake_o      = wake_q;
  assign err_o       = err_q;

  // R3
  wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |=> !wake_o);
  // R3
  wake_after_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> $past(v_ok_i) && supply_en_o);
  // R10
  no_wake_in_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wake_o && sleep_o));
  // R6
  sleep_keeps_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_o |-> supply_en_o);
  // R7
  sleep_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep_o) |-> !supply_en_o);
  // R8
  early_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(supply_en_o) && $past(sleep_o) && !$past(backup_done_i)) |-> err_o);
  // R2
  supply_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(supply_en_o) |-> $past(v_ok_i) && !$past(v_fail_i));
endmodule

// File: tb/pwr_seq_tb_top.sv
module pwr_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int STAB = 5;
  localparam int TMO  = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic v_ok = 1'b0, v_fail = 1'b0, done = 1'b0;
  logic supply_en, sleep, wake, err;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_seq #(.STABLE_CYCLES(STAB), .BACKUP_TIMEOUT(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .v_ok_i(v_ok), .v_fail_i(v_fail),
    .backup_done_i(done), .supply_en_o(supply_en), .sleep_o(sleep),
    .wake_o(wake), .err_o(err));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic power_up(input string req);
    int n = 0;
    @(negedge clk); v_ok = 1'b1; v_fail = 1'b0;
    @(negedge clk); n = 1;
    chk(supply_en == 1'b1 && wake == 1'b0, "R2 supply first", supply_en, 1);
    while (!wake && n < 60) begin @(negedge clk); n++; end
    chk(n == STAB + 2, req, n, STAB + 2);
    @(negedge clk);
    chk(wake == 1'b0, "R3 single pulse", wake, 0);
  endtask

  task automatic fail_and_ack(input int wait_cyc);
    v_fail = 1'b1; v_ok = 1'b0;
    @(negedge clk);
    chk(sleep == 1'b1 && supply_en == 1'b1, "R6 sleep raised", sleep, 1);
    repeat (wait_cyc) @(negedge clk);
    chk(supply_en == 1'b1 && sleep == 1'b1, "R7 held before ack", supply_en, 1);
    done = 1'b1;
    @(negedge clk); done = 1'b0;
    chk(supply_en == 1'b0 && sleep == 1'b0, "R7 release after ack", supply_en, 0);
    chk(err == 1'b0, "R7 err clear after ack", err, 0);
    v_fail = 1'b0;
  endtask

  task automatic t_reset;
    chk({supply_en, sleep, wake, err} == 4'b0, "R1 reset outputs",
        {supply_en, sleep, wake, err}, 0);
  endtask

  task automatic t_dropout;
    int n = 0;
    @(negedge clk); v_ok = 1'b1;
    repeat (4) begin @(negedge clk); n++; end
    v_ok = 1'b0;
    @(negedge clk); n++; v_ok = 1'b1;
    while (!wake && n < 60) begin @(negedge clk); n++; end
    chk(n == STAB + 5, "R4 dropout restarts count", n, STAB + 5);
    @(negedge clk);
  endtask

  task automatic t_fail_in_wait;
    int w = 0;
    @(negedge clk); v_ok = 1'b1;
    repeat (3) @(negedge clk);
    v_fail = 1'b1; v_ok = 1'b0;
    @(negedge clk);
    chk(supply_en == 1'b0, "R5 supply released in wait", supply_en, 0);
    repeat (20) begin @(negedge clk); if (wake) w++; end
    chk(w == 0, "R5 no wake after early fail", w, 0);
    v_fail = 1'b0;
  endtask

  task automatic t_timeout;
    int n = 0;
    v_fail = 1'b1; v_ok = 1'b0;
    @(negedge clk);
    while (sleep && n < 60) begin n++; @(negedge clk); end
    chk(n == TMO + 1, "R8 sleep length on timeout", n, TMO + 1);
    chk(supply_en == 1'b0, "R8 supply released on timeout", supply_en, 0);
    chk(err == 1'b1, "R8 err set", err, 1);
    v_fail = 1'b0;
    power_up("R3 wake latency after timeout");
    chk(err == 1'b1, "R8 err sticky", err, 1);
    fail_and_ack(3);
  endtask

  task automatic t_square;
    for (int i = 0; i < 4; i++) begin
      power_up("R9 square-wave wake latency");
      repeat (i) @(negedge clk);
      fail_and_ack(1 + i);
      chk(supply_en == 1'b0, "R9 off between episodes", supply_en, 0);
    end
  endtask

  int both = 0;
  always @(negedge clk) if (wake && sleep) both++;

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    power_up("R3 wake latency");
    fail_and_ack(4);
    t_dropout();
    v_fail = 1'b1; v_ok = 1'b0; @(negedge clk);
    @(negedge clk); done = 1'b1; @(negedge clk); done = 1'b0; v_fail = 1'b0;
    t_fail_in_wait();
    power_up("R3 wake latency after early fail");
    t_timeout();
    t_square();
    chk(both == 0, "R10 wake never with sleep", both, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule